// File: doc/BRIEF.md
# Hybrid Redundancy Voter with Spare Replacement

This block masks faults in a group of identical datapath copies. N primary copies (3 or 5) and S spare copies all present a result of the same width. A set of N voting slots, each bound to one copy, feeds a bitwise majority voter, and the voted word is the block's output.

Each cycle, every slot's value is compared with the vote. When an active copy disagrees, the slot-to-copy binding is rewritten at the next clock edge. The disagreeing copy is retired and the lowest-numbered unused spare takes its slot. The vote is combinational, so the output is already correct in the cycle the disagreement appears. A one-cycle pulse reports each replacement together with the retired copy's index. If a disagreement is seen when no spare is left, a sticky flag is raised and voting continues with the current set. Reset returns every copy to service.

Top module: `hybrid_redundancy_voter`

## Requirements
- R1: While reset is held and right after it is released, slot k is bound to primary copy k for k = 0..N-1, the next free spare is copy N, and `fault_pulse_o` and `spares_exhausted_o` are 0.
- R2: `voted_o` is, bit by bit, the majority of the N values currently bound to the voting slots. It is combinational from `mod_data_i`. Copy m drives bits `[m*DATA_W +: DATA_W]`; copies 0..N-1 are primaries and copies N..N+S-1 are spares.
- R3: A slot is in disagreement when its value differs from `voted_o` in any bit. If several slots disagree in one cycle, only the lowest-numbered slot is acted on.
- R4: When a slot disagrees and a spare remains, the spare is bound to that slot from the next rising edge on. `voted_o` is not delayed by this and is correct in the disagreement cycle.
- R5: `fault_pulse_o` is 1 for exactly the one cycle after each replacement edge. In that cycle `retired_idx_o` holds the number of the copy that was removed.
- R6: In a cycle with no disagreement, the slot bindings do not change and no pulse follows.
- R7: A disagreement seen when no spare is left sets `spares_exhausted_o` from the next edge on. The flag stays set until reset. No pulse is produced and the bindings are left unchanged.
- R8: Values on free spares and on retired copies have no effect on `voted_o`, on the pulse, or on the flags.
- R9: Spares are handed out in ascending copy order (N first, then N+1, and so on).
- R10: The asynchronous active-low reset returns retired copies to service and clears the exhausted flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_data_i | input | (N_PRIMARY+N_SPARE)*DATA_W | Results of all copies, copy m at `[m*DATA_W +: DATA_W]` |
| voted_o | output | DATA_W | Majority-voted result of the active slots |
| fault_pulse_o | output | 1 | One-cycle pulse after each replacement |
| retired_idx_o | output | $clog2(N_PRIMARY+N_SPARE) | Copy removed by the latest replacement |
| spares_exhausted_o | output | 1 | Sticky: disagreement seen with no spare left |

## Verification
The properties assume that `mod_data_i` carries known values and changes only between clock edges. They do not rely on the single-failure assumption. The bench drives every input at the falling edge. It lets at most one active copy disagree per cycle during the random phase, so its reference vote always equals the intended word. Multi-slot disagreement is limited to one directed case, where two copies are corrupted on disjoint bit masks; there the vote stays correct and the lowest-slot rule can be checked. Free and retired copies always carry random words, so any leak of their values into the vote or the compare logic shows up at the ports.

// File: rtl/hv_pkg.sv
package hv_pkg;
  localparam int unsigned MAX_VOTERS = 8;

  // bitwise majority of the lower n bits of v
  function automatic logic vote_bit(input logic [MAX_VOTERS-1:0] v, input int unsigned n);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i < MAX_VOTERS; i++)
      if (i < n && v[i]) cnt++;
    return (cnt * 2) > n;
  endfunction
endpackage

// File: rtl/hv_slot_mux.sv
module hv_slot_mux #(
  parameter int unsigned N_SLOT = 3,
  parameter int unsigned N_MOD  = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [N_MOD*DATA_W-1:0]  mod_data_i,
  input  logic [N_SLOT*IDX_W-1:0]  slot_map_i,
  output logic [N_SLOT*DATA_W-1:0] slot_data_o
);
  logic [DATA_W-1:0] mod_arr [N_MOD];

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    assign mod_arr[m] = mod_data_i[m*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    logic [IDX_W-1:0] sel;
    assign sel = slot_map_i[k*IDX_W +: IDX_W];
    assign slot_data_o[k*DATA_W +: DATA_W] = mod_arr[sel];
  end
endmodule

// File: rtl/hv_majority.sv
module hv_majority
  import hv_pkg::*;
#(
  parameter int unsigned N_SLOT = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_SLOT*DATA_W-1:0] slot_data_i,
  output logic [DATA_W-1:0]        voted_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [MAX_VOTERS-1:0] col;
    always_comb begin
      col = '0;
      for (int k = 0; k < int'(N_SLOT); k++) col[k] = slot_data_i[k*DATA_W + b];
    end
    assign voted_o[b] = vote_bit(col, N_SLOT);
  end
endmodule

// File: rtl/hv_compare.sv
module hv_compare #(
  parameter int unsigned N_SLOT = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOT_W = 2
) (
  input  logic [N_SLOT*DATA_W-1:0] slot_data_i,
  input  logic [DATA_W-1:0]        voted_i,
  output logic                     mism_any_o,
  output logic [SLOT_W-1:0]        mism_slot_o,
  output logic [N_SLOT-1:0]        mism_sel_o
);
  logic [N_SLOT-1:0] mism;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_cmp
    assign mism[k] = slot_data_i[k*DATA_W +: DATA_W] != voted_i;
  end

  // lowest disagreeing slot wins
  always_comb begin
    mism_slot_o = '0;
    mism_sel_o  = '0;
    for (int k = int'(N_SLOT) - 1; k >= 0; k--) begin
      if (mism[k]) begin
        mism_slot_o = SLOT_W'(k);
        mism_sel_o  = N_SLOT'(1) << k;
      end
    end
  end

  assign mism_any_o = |mism;
endmodule

// File: rtl/hv_reconfig.sv
module hv_reconfig #(
  parameter int unsigned N_SLOT = 3,
  parameter int unsigned N_MOD  = 5,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned SLOT_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mism_any_i,
  input  logic [SLOT_W-1:0]       mism_slot_i,
  output logic [N_SLOT*IDX_W-1:0] slot_map_o,
  output logic                    fault_pulse_o,
  output logic [IDX_W-1:0]        retired_idx_o,
  output logic                    exhausted_o
);
  localparam int unsigned CNT_W = $clog2(N_MOD + 1);
  localparam logic [CNT_W-1:0] FIRST_SPARE = CNT_W'(N_SLOT);
  localparam logic [CNT_W-1:0] MOD_END     = CNT_W'(N_MOD);

  logic [IDX_W-1:0] slot_q [N_SLOT];
  logic [CNT_W-1:0] next_spare_q;
  logic             spare_left;

  assign spare_left = next_spare_q < MOD_END;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(N_SLOT); k++) slot_q[k] <= IDX_W'(k);
      next_spare_q  <= FIRST_SPARE;
      fault_pulse_o <= 1'b0;
      retired_idx_o <= '0;
      exhausted_o   <= 1'b0;
    end else begin
      fault_pulse_o <= 1'b0;
      if (mism_any_i) begin
        if (spare_left) begin
          slot_q[mism_slot_i] <= next_spare_q[IDX_W-1:0];
          retired_idx_o       <= slot_q[mism_slot_i];
          next_spare_q        <= next_spare_q + 1'b1;
          fault_pulse_o       <= 1'b1;
        end else begin
          exhausted_o <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_map
    assign slot_map_o[k*IDX_W +: IDX_W] = slot_q[k];
  end

  AST_SWAP_ON_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mism_any_i && spare_left |=> fault_pulse_o); // R4
  AST_NO_SWAP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mism_any_i |=> !fault_pulse_o && $stable(slot_map_o)); // R6
  AST_EXHAUST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhausted_o |=> exhausted_o); // R7
  AST_EXHAUST_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mism_any_i && !spare_left |=> !fault_pulse_o && $stable(slot_map_o)); // R7
  AST_SPARE_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |-> next_spare_q == $past(next_spare_q) + 1'b1); // R9
endmodule

// File: rtl/hybrid_redundancy_voter.sv
module hybrid_redundancy_voter #(
  parameter int unsigned N_PRIMARY = 3,
  parameter int unsigned N_SPARE   = 2,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [(N_PRIMARY+N_SPARE)*DATA_W-1:0]     mod_data_i,
  output logic [DATA_W-1:0]                         voted_o,
  output logic                                      fault_pulse_o,
  output logic [$clog2(N_PRIMARY+N_SPARE)-1:0]      retired_idx_o,
  output logic                                      spares_exhausted_o
);
  localparam int unsigned N_MOD  = N_PRIMARY + N_SPARE;
  localparam int unsigned IDX_W  = $clog2(N_MOD);
  localparam int unsigned SLOT_W = $clog2(N_PRIMARY);

  logic [N_PRIMARY*IDX_W-1:0]  slot_map;
  logic [N_PRIMARY*DATA_W-1:0] slot_data;
  logic                        mism_any;
  logic [SLOT_W-1:0]           mism_slot;
  logic [N_PRIMARY-1:0]        mism_sel;

  hv_slot_mux #(.N_SLOT(N_PRIMARY), .N_MOD(N_MOD), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
    .mod_data_i (mod_data_i),
    .slot_map_i (slot_map),
    .slot_data_o(slot_data)
  );

  hv_majority #(.N_SLOT(N_PRIMARY), .DATA_W(DATA_W)) u_vote (
    .slot_data_i(slot_data),
    .voted_o    (voted_o)
  );

  hv_compare #(.N_SLOT(N_PRIMARY), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_cmp (
    .slot_data_i(slot_data),
    .voted_i    (voted_o),
    .mism_any_o (mism_any),
    .mism_slot_o(mism_slot),
    .mism_sel_o (mism_sel)
  );

  hv_reconfig #(.N_SLOT(N_PRIMARY), .N_MOD(N_MOD), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mism_any_i   (mism_any),
    .mism_slot_i  (mism_slot),
    .slot_map_o   (slot_map),
    .fault_pulse_o(fault_pulse_o),
    .retired_idx_o(retired_idx_o),
    .exhausted_o  (spares_exhausted_o)
  );

  AST_ONE_SLOT_ACTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mism_sel) && (mism_any == (mism_sel != '0))); // R3
  AST_UNANIMOUS_VOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mism_any |-> voted_o == slot_data[DATA_W-1:0]); // R2
  AST_RETIRED_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |-> slot_map[mism_slot*IDX_W +: IDX_W] != retired_idx_o || $past(mism_slot) != mism_slot); // R4
endmodule

// File: tb/hybrid_redundancy_voter_tb.sv
module hybrid_redundancy_voter_tb;
  localparam int NP = 3, NS = 2, W = 8, NM = NP + NS, IW = $clog2(NM);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NM*W-1:0]   mod_data = '0;
  logic [W-1:0]      voted;
  logic              pulse;
  logic [IW-1:0]     ridx;
  logic              exh;

  int n_tests = 0, n_fail = 0;

  // reference model state
  int smap [NP];
  int nsp;
  bit m_exh;
  logic [W-1:0] dat [NM];

  always #10 clk = ~clk;

  hybrid_redundancy_voter #(.N_PRIMARY(NP), .N_SPARE(NS), .DATA_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mod_data_i(mod_data),
    .voted_o(voted), .fault_pulse_o(pulse), .retired_idx_o(ridx),
    .spares_exhausted_o(exh)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int k = 0; k < NP; k++) smap[k] = k;
    nsp = NP;
    m_exh = 0;
  endfunction

  function automatic logic [W-1:0] model_vote();
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) begin
      int c = 0;
      for (int k = 0; k < NP; k++) c += int'(dat[smap[k]][b]);
      v[b] = (2 * c > NP);
    end
    return v;
  endfunction

  // active slots carry base; others random; optional corruption of up to two slots
  task automatic set_data(input logic [W-1:0] base, input int s1, input logic [W-1:0] m1,
                          input int s2, input logic [W-1:0] m2);
    for (int m = 0; m < NM; m++) dat[m] = W'($urandom);
    for (int k = 0; k < NP; k++) dat[smap[k]] = base;
    if (s1 >= 0) dat[smap[s1]] ^= m1;
    if (s2 >= 0) dat[smap[s2]] ^= m2;
    for (int m = 0; m < NM; m++) mod_data[m*W +: W] = dat[m];
  endtask

  // called just after a falling edge with data set; returns after the next falling edge
  task automatic step(input string tag);
    logic [W-1:0] ev;
    int ms;
    bit ep;
    int ei;
    #1;
    ev = model_vote();
    chk(voted == ev, {tag, " R2 vote"}, int'(voted), int'(ev));
    ms = -1;
    for (int k = NP - 1; k >= 0; k--) if (dat[smap[k]] != ev) ms = k;
    ep = 0; ei = 0;
    if (ms >= 0) begin
      if (nsp < NM) begin
        ep = 1; ei = smap[ms]; smap[ms] = nsp; nsp++;
      end else m_exh = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(pulse == ep, {tag, " R5 pulse"}, int'(pulse), int'(ep));
    if (ep) chk(int'(ridx) == ei, {tag, " R5 retired index"}, int'(ridx), ei);
    chk(exh == m_exh, {tag, " R7 exhausted"}, int'(exh), int'(m_exh));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    model_reset();
    chk(pulse == 1'b0, "R1 pulse in reset", int'(pulse), 0);
    chk(exh == 1'b0, "R10 exhausted cleared", int'(exh), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] a;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();

    // R1/R8: primaries agree, spares hold the inverse
    a = 8'h3c;
    for (int m = 0; m < NM; m++) dat[m] = (m < NP) ? a : ~a;
    for (int m = 0; m < NM; m++) mod_data[m*W +: W] = dat[m];
    #1;
    chk(voted == a, "R1 primaries bound after reset", int'(voted), int'(a));
    step("R8 spares ignored");

    for (int i = 0; i < 40; i++) begin
      set_data(W'($urandom), -1, '0, -1, '0);
      step("R6 clean");
    end

    // R4/R9: slot 1 disagrees, spare 3 must replace copy 1
    set_data(8'ha5, 1, 8'h01, -1, '0);
    step("R4 first swap");
    set_data(8'h5a, -1, '0, -1, '0);
    dat[1] = 8'hff; mod_data[1*W +: W] = dat[1];
    step("R8 retired copy ignored");
    chk(smap[1] == 3, "R9 first spare is copy 3", smap[1], 3);

    set_data(8'h77, 0, 8'h80, -1, '0);
    step("R9 second swap");
    set_data(8'h12, -1, '0, -1, '0);
    step("R9 copy 4 in slot 0");

    // R7: no spare left
    set_data(8'hc3, 2, 8'h10, -1, '0);
    step("R7 exhaust");
    for (int i = 0; i < 10; i++) begin
      set_data(W'($urandom), (i % 3 == 0) ? i % NP : -1, 8'h04, -1, '0);
      step("R7 sticky");
    end

    // R10 then R3: two slots disagree on disjoint bits, lowest slot handled
    @(negedge clk);
    do_reset();
    set_data(8'h96, -1, '0, -1, '0);
    step("R10 primaries back");
    set_data(8'h96, 2, 8'hf0, 1, 8'h0f);
    step("R3 lowest slot");
    chk(smap[1] == 3, "R3 slot 1 replaced", smap[1], 3);
    set_data(8'h00, -1, '0, -1, '0);
    step("R3 slot 2 kept");

    // random phase with single transient faults and occasional reset
    for (int i = 0; i < 3000; i++) begin
      if (i % 400 == 399) begin
        @(negedge clk);
        do_reset();
      end
      if ($urandom_range(0, 9) == 0)
        set_data(W'($urandom), $urandom_range(0, NP - 1), W'($urandom_range(1, 255)), -1, '0);
      else
        set_data(W'($urandom), -1, '0, -1, '0);
      step("R4 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule